// File: doc/BRIEF.md
# Banked Interrupt Controller with Global Mask

This block is a second-level interrupt controller. It accepts `NUM_SEC` groups of 32 interrupt lines and presents one IRQ and one FIQ request to a processor. Each group, called a section, has its own pending, mask and routing registers. These registers are reached over a plain 32-bit register bus. The same register layout repeats every 0x100 bytes, so software finds section `s` at base `s*0x100`. A small set of shared registers appears only in section 0: the two lowest-index reports, a control word, a status word, a bus configuration byte and a revision constant.

Setting the global mask freezes interrupt delivery in an orderly way. Sources that were active when the mask was set stay visible on IRQ/FIQ until software clears or masks them. Sources that arrive later are latched but are not shown. Once nothing from that first group remains, the active-low secure-mask output asserts. It stays asserted until the global mask is cleared.

A spy port returns the raw pending word of any section with no clock delay, whatever state the controller is in. The default configuration has two sections and an 11-bit byte address.

Top module: `bic_top`

## Requirements
- R1: A pending bit is set by the clock edge at which its source line is sampled high after being sampled low. Writing 1 to that bit at section offset 0x00 clears it. If a rising edge and a clear hit the same cycle, the bit stays set.
- R2: In section `s`, the pending word is at byte address `s*0x100+0x00`, the mask word at `+0x04` (reset all ones, 1 = masked) and the route word at `+0x08` (reset 0, 1 = FIQ, 0 = IRQ). Bit n of each word is interrupt `s*32+n` (little-endian).
- R3: The following locations read 0 and ignore writes: a section number at or above `NUM_SEC`, any offset not listed in R2 or R9, any address that is not word aligned, and the shared offsets in any section other than 0.
- R4: While the global mask is clear, `irq_o` is high exactly when some pending, unmasked interrupt has route 0. `fiq_o` is high exactly when such an interrupt has route 1.
- R5: In section 0, offset 0x10 reads the lowest interrupt number among presented IRQ sources and offset 0x14 does the same for FIQ sources. Each reads 0xFFFF_FFFF when there is no such source.
- R6: Writing bit 0 = 1 to control (section 0, offset 0x18) sets the global mask. From then on only sources that were active at that write keep driving IRQ/FIQ, and each one drops out once it is cleared or masked. Writing bit 0 = 0 clears the global mask and restores R4 delivery. Control bit 0 reads 1 while the mask is set.
- R7: `secure_mask_no` goes low one clock after the captured set of sources becomes empty. It stays low, with IRQ/FIQ held low, until the global mask is cleared. It is high whenever the global mask is clear.
- R8: Status (section 0, offset 0xA0) reads bit 0 = draining and bit 1 = secure mask asserted.
- R9: Section 0 holds two more registers. Offset 0xA4 is an 8-bit read/write configuration byte (reset 0). Offset 0xA8 reads the constant `REVISION` (default 0x21).
- R10: `spy_o` combinationally equals the pending word of section `spy_sel_i`, or 0 when the select is at or above `NUM_SEC`. It does not depend on the mask or global-mask state.
- R11: `bus_rdata_o` is updated at the clock edge of a read request (`bus_req_i` high, `bus_we_i` low) and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SEC*32 | Interrupt source lines, edge detected |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| secure_mask_no | output | 1 | Active-low secure-mask handshake |
| spy_sel_i | input | SEL_W | Section number for the spy port |
| spy_o | output | 32 | Raw pending word of the selected section |

## Verification
Random source toggles are mixed with random pending clears and random mask and route writes across both sections. This shows whether edge latching, clearing and IRQ/FIQ routing are each tied to the correct section rather than to one fixed bank. Random spy selects that include out-of-range section numbers separate a correct section mux from one that aliases or wraps. Directed sequences cover the rest:
- writes to mirrored shared offsets and to unused or out-of-range locations, which expose decode that ignores the section number;
- a clear that collides with a rising edge, which tests set priority;
- global-mask runs that start with live sources and with none, which tell the drain phase apart from an immediate lock and show that late arrivals stay hidden.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned SEC_W = 32;

  localparam logic [7:0] OFF_PEND     = 8'h00;
  localparam logic [7:0] OFF_MASK     = 8'h04;
  localparam logic [7:0] OFF_ROUTE    = 8'h08;
  localparam logic [7:0] OFF_SORT_IRQ = 8'h10;
  localparam logic [7:0] OFF_SORT_FIQ = 8'h14;
  localparam logic [7:0] OFF_CTRL     = 8'h18;
  localparam logic [7:0] OFF_STAT     = 8'hA0;
  localparam logic [7:0] OFF_BCFG     = 8'hA4;
  localparam logic [7:0] OFF_REV      = 8'hA8;

  typedef enum logic [1:0] {
    GM_OPEN   = 2'd0,
    GM_DRAIN  = 2'd1,
    GM_LOCKED = 2'd2
  } gm_state_e;
endpackage

// File: rtl/bic_section.sv
module bic_section #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic         route_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] route_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pend_o  <= '0;
      mask_o  <= '1;
      route_o <= '0;
    end else begin
      prev_q <= src_i;
      // set wins over clear
      pend_o <= (pend_o & ~clr) | (src_i & ~prev_q);
      if (mask_we_i)  mask_o  <= wdata_i;
      if (route_we_i) route_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bic_lowest.sv
module bic_lowest #(
  parameter int unsigned N   = 64,
  parameter int unsigned IDW = 6
) (
  input  logic [N-1:0]   vec_i,
  output logic           found_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/bic_gmask.sv
module bic_gmask
  import bic_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      set_i,
  input  logic      clr_i,
  input  logic [N-1:0] active_i,
  output gm_state_e state_o,
  output logic [N-1:0] present_o
);
  logic [N-1:0] drain_q;
  logic [N-1:0] still;

  assign still = drain_q & active_i;

  always_comb begin
    unique case (state_o)
      GM_OPEN:  present_o = active_i;
      GM_DRAIN: present_o = still;
      default:  present_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= GM_OPEN;
      drain_q <= '0;
    end else if (clr_i) begin
      state_o <= GM_OPEN;
      drain_q <= '0;
    end else begin
      unique case (state_o)
        GM_OPEN: if (set_i) begin
          state_o <= GM_DRAIN;
          drain_q <= active_i;
        end
        GM_DRAIN: begin
          drain_q <= still;
          if (still == '0) state_o <= GM_LOCKED;
        end
        default: state_o <= GM_LOCKED;
      endcase
    end
  end
endmodule

// File: rtl/bic_top.sv
module bic_top
  import bic_pkg::*;
#(
  parameter int unsigned NUM_SEC  = 2,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BCFG_W   = 8,
  parameter logic [31:0] REVISION = 32'h0000_0021
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SEC*SEC_W-1:0]   src_i,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic                       irq_o,
  output logic                       fiq_o,
  output logic                       secure_mask_no,
  input  logic [SEL_W-1:0]           spy_sel_i,
  output logic [31:0]                spy_o
);
  localparam int unsigned NI   = NUM_SEC * SEC_W;
  localparam int unsigned IDW  = $clog2(NI);
  localparam int unsigned SECW = ADDR_W - 8;

  logic [SECW-1:0] sec_idx;
  logic [7:0]      off;
  logic            wr, rd, sec0;

  assign sec_idx = bus_addr_i[ADDR_W-1:8];
  assign off     = bus_addr_i[7:0];
  assign wr      = bus_req_i & bus_we_i;
  assign rd      = bus_req_i & ~bus_we_i;
  assign sec0    = (sec_idx == '0);

  logic [SEC_W-1:0] pend_w  [NUM_SEC];
  logic [SEC_W-1:0] mask_w  [NUM_SEC];
  logic [SEC_W-1:0] route_w [NUM_SEC];
  logic [NI-1:0]    pend_all, mask_all, route_all, active, present;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic hit;
    assign hit = wr && (sec_idx == SECW'(s));
    bic_section #(.W(SEC_W)) u_sec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[s*SEC_W +: SEC_W]),
      .clr_we_i   (hit && off == OFF_PEND),
      .mask_we_i  (hit && off == OFF_MASK),
      .route_we_i (hit && off == OFF_ROUTE),
      .wdata_i    (bus_wdata_i),
      .pend_o     (pend_w[s]),
      .mask_o     (mask_w[s]),
      .route_o    (route_w[s])
    );
    assign pend_all[s*SEC_W +: SEC_W]  = pend_w[s];
    assign mask_all[s*SEC_W +: SEC_W]  = mask_w[s];
    assign route_all[s*SEC_W +: SEC_W] = route_w[s];
  end

  assign active = pend_all & ~mask_all;

  gm_state_e gm_state;
  logic      ctrl_we;
  assign ctrl_we = wr && sec0 && off == OFF_CTRL;

  bic_gmask #(.N(NI)) u_gmask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ctrl_we && bus_wdata_i[0]),
    .clr_i     (ctrl_we && !bus_wdata_i[0]),
    .active_i  (active),
    .state_o   (gm_state),
    .present_o (present)
  );

  logic [NI-1:0]  irq_vec, fiq_vec;
  logic           irq_found, fiq_found;
  logic [IDW-1:0] irq_idx, fiq_idx;

  assign irq_vec = present & ~route_all;
  assign fiq_vec = present & route_all;
  assign irq_o   = |irq_vec;
  assign fiq_o   = |fiq_vec;
  assign secure_mask_no = (gm_state != GM_LOCKED);

  bic_lowest #(.N(NI), .IDW(IDW)) u_low_irq (
    .vec_i(irq_vec), .found_o(irq_found), .idx_o(irq_idx)
  );
  bic_lowest #(.N(NI), .IDW(IDW)) u_low_fiq (
    .vec_i(fiq_vec), .found_o(fiq_found), .idx_o(fiq_idx)
  );

  logic [BCFG_W-1:0] bcfg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              bcfg_q <= '0;
    else if (wr && sec0 && off == OFF_BCFG)   bcfg_q <= bus_wdata_i[BCFG_W-1:0];
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int s = 0; s < int'(NUM_SEC); s++) begin
      if (sec_idx == SECW'(s)) begin
        case (off)
          OFF_PEND:  rd_val = pend_w[s];
          OFF_MASK:  rd_val = mask_w[s];
          OFF_ROUTE: rd_val = route_w[s];
          default:   ;
        endcase
      end
    end
    if (sec0) begin
      case (off)
        OFF_SORT_IRQ: rd_val = irq_found ? 32'(irq_idx) : '1;
        OFF_SORT_FIQ: rd_val = fiq_found ? 32'(fiq_idx) : '1;
        OFF_CTRL:     rd_val = {31'b0, gm_state != GM_OPEN};
        OFF_STAT:     rd_val = {30'b0, gm_state == GM_LOCKED, gm_state == GM_DRAIN};
        OFF_BCFG:     rd_val = 32'(bcfg_q);
        OFF_REV:      rd_val = REVISION;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rd_val;
  end

  always_comb begin
    spy_o = '0;
    for (int s = 0; s < int'(NUM_SEC); s++) begin
      if (spy_sel_i == SEL_W'(s)) spy_o = pend_w[s];
    end
  end
endmodule

// File: rtl/bic_checker.sv
module bic_checker
  import bic_pkg::*;
#(
  parameter int unsigned NUM_SEC = 2,
  parameter int unsigned SEL_W   = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_SEC*32-1:0]  src_i,
  input logic [NUM_SEC*32-1:0]  pend_all,
  input logic [NUM_SEC*32-1:0]  mask_all,
  input logic [NUM_SEC*32-1:0]  route_all,
  input logic [NUM_SEC*32-1:0]  present,
  input logic                   irq_o,
  input logic                   fiq_o,
  input logic                   secure_mask_no,
  input logic [SEL_W-1:0]       spy_sel_i,
  input logic [31:0]            spy_o,
  input gm_state_e              gm_state
);
  p_edge_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_i[0]) |=> pend_all[0]);

  p_irq_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gm_state == GM_OPEN |-> irq_o == |(pend_all & ~mask_all & ~route_all));

  p_fiq_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gm_state == GM_OPEN |-> fiq_o == |(pend_all & ~mask_all & route_all));

  p_drain_no_new_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gm_state == GM_DRAIN && $past(gm_state) == GM_DRAIN) |->
      (present & ~$past(present)) == '0);

  p_locked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !secure_mask_no |-> !irq_o && !fiq_o);

  p_lock_after_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(secure_mask_no) |-> $past(gm_state) == GM_DRAIN);

  p_spy_sec0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spy_sel_i == '0 |-> spy_o == pend_all[31:0]);
endmodule

bind bic_top bic_checker #(.NUM_SEC(NUM_SEC), .SEL_W(SEL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .src_i          (src_i),
  .pend_all       (pend_all),
  .mask_all       (mask_all),
  .route_all      (route_all),
  .present        (present),
  .irq_o          (irq_o),
  .fiq_o          (fiq_o),
  .secure_mask_no (secure_mask_no),
  .spy_sel_i      (spy_sel_i),
  .spy_o          (spy_o),
  .gm_state       (gm_state)
);

// File: tb/bic_top_bench.sv
module bic_top_bench;
  localparam int NUM_SEC = 2;
  localparam int NI      = NUM_SEC * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] src_i = '0;
  logic          bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [10:0]   bus_addr_i = '0;
  logic [31:0]   bus_wdata_i = '0;
  logic [31:0]   bus_rdata_o;
  logic          irq_o, fiq_o, secure_mask_no;
  logic [2:0]    spy_sel_i = '0;
  logic [31:0]   spy_o;

  always #4 clk_i = ~clk_i;

  bic_top u_bic_top (
    .clk_i, .rst_ni, .src_i, .bus_req_i, .bus_we_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o, .irq_o, .fiq_o, .secure_mask_no,
    .spy_sel_i, .spy_o
  );

  int checks = 0, errors = 0;
  logic [NI-1:0] m_pend = '0, m_mask = '1, m_route = '0, m_prev = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [NI-1:0] v);
    for (int i = 0; i < NI; i++) if (v[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] spy_exp(input logic [2:0] sel);
    return (sel < NUM_SEC) ? m_pend[sel*32 +: 32] : 32'h0;
  endfunction

  task automatic tick(input logic [NI-1:0] src, input logic wr,
                      input logic [10:0] a, input logic [31:0] d);
    int sec;
    @(negedge clk_i);
    src_i = src; bus_req_i = wr; bus_we_i = wr; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    sec = int'(a[10:8]);
    if (wr && sec < NUM_SEC) begin
      case (a[7:0])
        8'h00: m_pend[sec*32 +: 32] &= ~d;
        8'h04: m_mask[sec*32 +: 32] = d;
        8'h08: m_route[sec*32 +: 32] = d;
        default: ;
      endcase
    end
    m_pend |= src & ~m_prev;
    m_prev = src;
    #1;
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic wr32(input logic [10:0] a, input logic [31:0] d);
    tick(src_i, 1'b1, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [10:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(posedge clk_i);
    #1;
    bus_req_i = 1'b0;
    chk(req, bus_rdata_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // reset state
    chk("R4 reset irq", 32'(irq_o), 0);
    chk("R4 reset fiq", 32'(fiq_o), 0);
    chk("R7 reset secure", 32'(secure_mask_no), 1);
    chk("R10 reset spy", spy_o, 0);
    rd_chk("R2 mask reset", 11'h004, 32'hFFFF_FFFF);
    rd_chk("R9 revision", 11'h0A8, 32'h0000_0021);
    rd_chk("R11 hold", 11'h0A8, 32'h0000_0021);

    // R2 stride
    wr32(11'h104, 32'h0000_00F0);
    rd_chk("R2 sec1 mask", 11'h104, 32'h0000_00F0);
    rd_chk("R2 sec0 mask untouched", 11'h004, 32'hFFFF_FFFF);
    wr32(11'h004, 32'h0);
    wr32(11'h008, 32'h0000_FF00);
    rd_chk("R2 sec0 route", 11'h008, 32'h0000_FF00);

    // R3 mirrors, holes, out-of-range
    wr32(11'h118, 32'h1);
    chk("R3 mirror ctrl no lock", 32'(secure_mask_no), 1);
    rd_chk("R3 ctrl unchanged", 11'h018, 32'h0);
    rd_chk("R3 mirror ctrl reads 0", 11'h118, 32'h0);
    rd_chk("R3 mirror rev reads 0", 11'h1A8, 32'h0);
    wr32(11'h1A4, 32'hFF);
    rd_chk("R3 mirror bcfg ignored", 11'h0A4, 32'h0);
    rd_chk("R3 unused offset", 11'h0C0, 32'h0);
    wr32(11'h204, 32'h0);
    rd_chk("R3 out of range sec", 11'h204, 32'h0);
    wr32(11'h006, 32'h5);
    rd_chk("R3 misaligned ignored", 11'h004, 32'h0);

    // R9 config byte
    wr32(11'h0A4, 32'h1FF);
    rd_chk("R9 bcfg width", 11'h0A4, 32'h0000_00FF);

    // R1/R4/R10 random
    for (int it = 0; it < 400; it++) begin
      logic [NI-1:0] s;
      logic          w;
      logic [10:0]   a;
      s = {$urandom, $urandom};
      w = ($urandom % 3) == 0;
      a = {3'($urandom % 2), 8'(4 * ($urandom % 3))};
      spy_sel_i = 3'($urandom % 4);
      tick(s, w, a, $urandom);
      chk("R4 irq random", 32'(irq_o), 32'(|(m_pend & ~m_mask & ~m_route)));
      chk("R4 fiq random", 32'(fiq_o), 32'(|(m_pend & ~m_mask & m_route)));
      chk("R10 spy random", spy_o, spy_exp(spy_sel_i));
      if (it % 25 == 0) begin
        rd_chk("R5 sorted irq", 11'h010, lowest(m_pend & ~m_mask & ~m_route));
        rd_chk("R5 sorted fiq", 11'h014, lowest(m_pend & ~m_mask & m_route));
        rd_chk("R1 pending sec1", 11'h100, m_pend[63:32]);
      end
    end

    // R1 clear vs set collision
    wr32(11'h004, 32'h0);
    wr32(11'h008, 32'h0000_FF00);
    wr32(11'h104, 32'h0);
    wr32(11'h108, 32'h0);
    tick('0, 1'b0, 11'h0, 32'h0);
    wr32(11'h000, 32'hFFFF_FFFF);
    wr32(11'h100, 32'hFFFF_FFFF);
    rd_chk("R5 sorted none", 11'h010, 32'hFFFF_FFFF);
    tick(NI'(64'h4), 1'b1, 11'h000, 32'h4);
    rd_chk("R1 set wins", 11'h000, 32'h4);
    wr32(11'h000, 32'h4);
    rd_chk("R1 clear", 11'h000, 32'h0);

    // R6/R7/R8 drain with live sources
    tick(NI'(64'h208), 1'b0, 11'h0, 32'h0);
    wr32(11'h018, 32'h1);
    chk("R6 irq kept", 32'(irq_o), 1);
    chk("R6 fiq kept", 32'(fiq_o), 1);
    chk("R7 not yet", 32'(secure_mask_no), 1);
    rd_chk("R8 draining", 11'h0A0, 32'h1);
    rd_chk("R6 ctrl readback", 11'h018, 32'h1);
    tick(NI'(64'h218), 1'b0, 11'h0, 32'h0);
    rd_chk("R6 sorted keeps old", 11'h010, 32'h3);
    wr32(11'h000, 32'h8);
    chk("R6 irq dropped", 32'(irq_o), 0);
    chk("R6 fiq still", 32'(fiq_o), 1);
    wr32(11'h000, 32'h200);
    chk("R6 fiq dropped", 32'(fiq_o), 0);
    tick(src_i, 1'b0, 11'h0, 32'h0);
    chk("R7 lock asserted", 32'(secure_mask_no), 0);
    chk("R6 late source hidden", 32'(irq_o), 0);
    rd_chk("R8 locked", 11'h0A0, 32'h2);
    spy_sel_i = 3'd0;
    #1 chk("R10 spy while locked", spy_o, 32'h10);
    wr32(11'h018, 32'h0);
    chk("R7 released", 32'(secure_mask_no), 1);
    chk("R6 late source delivered", 32'(irq_o), 1);

    // R7 drain with nothing active
    wr32(11'h000, 32'hFFFF_FFFF);
    wr32(11'h018, 32'h1);
    chk("R7 empty drain first cycle", 32'(secure_mask_no), 1);
    tick(src_i, 1'b0, 11'h0, 32'h0);
    chk("R7 empty drain locks", 32'(secure_mask_no), 0);
    wr32(11'h018, 32'h0);
    chk("R7 open again", 32'(secure_mask_no), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule